// File: doc/BRIEF.md
# Burst Beat Address Sequencer

This block produces the word address for each beat of a four-beat burst in front of a synchronous pipelined memory array. When a burst begins, it captures the complete external word address. The two lowest bits seed a two-bit beat counter, and the upper bits are held as a fixed block base. Each later clock edge that sees the advance strobe moves the counter forward by one beat. The low address bits then follow one of two orders. In linear order they step through the four-word block and wrap around. In interleaved order they are the seed XORed with the beat number.

A burst can be opened by either of two start strobes. The first belongs to the host processor and the second to a cache controller. Both take effect only while the chip-select input is high. When both arrive in the same cycle, the processor strobe has priority. Because both load the same address, the result is one clean burst start. The order select is captured at the start edge and applies to that whole burst. The sequencer samples every input only on the rising clock edge. The address output is a registered value that settles one edge after the command that changed it.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the following `addr_out` is all zeros.
- R2: A rising edge with `sel`=1 and `start_ctrl`=1 makes `addr_out` equal to the `addr_in` sampled at that edge (beat 0).
- R3: A rising edge with `sel`=1 and `start_proc`=1 makes `addr_out` equal to the `addr_in` sampled at that edge (beat 0).
- R4: With `sel`=0, neither start strobe changes `addr_out`.
- R5: An edge with no accepted start and `adv`=0 leaves `addr_out` unchanged.
- R6: For a burst started with `order_sel`=0 from seed s, the low two bits after n advances are (s+n) mod 4.
- R7: For a burst started with `order_sel`=1 from seed s, the low two bits after n advances are s XOR n.
- R8: Address bits above bit 1 keep the value captured at the start for the whole burst, whatever `addr_in` does afterwards.
- R9: The fourth advance returns `addr_out` to the start address. The burst stays inside its four-word block.
- R10: Changing `order_sel` after the start edge does not affect the order of the running burst.
- R11: An accepted start in the same edge as `adv`=1 gives beat 0 of the new burst, not an advanced address.
- R12: With `sel`=1 and both start strobes high at once, `addr_out` becomes the sampled `addr_in` at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Chip select; qualifies both start strobes |
| start_proc | input | 1 | Processor-side burst start strobe (higher priority) |
| start_ctrl | input | 1 | Controller-side burst start strobe |
| adv | input | 1 | Advance to the next beat |
| order_sel | input | 1 | 0 = linear wrap order, 1 = interleaved XOR order; captured at start |
| addr_in | input | ADDR_W | External word address |
| addr_out | output | ADDR_W | Current internal beat address |

## Verification
On every cycle the assertions check four things. An accepted start loads the sampled address. An idle edge holds the output. The upper bits never move without a start. Every advance changes the low two bits. Only the bench's sweep can show that the low bits follow the exact (s+n) mod 4 or s XOR n values, that the mode stays locked to the value captured at the start, and that the fourth advance returns to the start address. That sweep covers every seed, both orders and every strobe combination.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    // Beat ordering captured at burst start.
    typedef enum logic {
        ORDER_WRAP = 1'b0,
        ORDER_XOR  = 1'b1
    } order_e;

    // Per-edge command decoded from the strobes.
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } seq_cmd_e;

    // Which strobe won an accepted start.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } start_src_e;

    typedef struct packed {
        seq_cmd_e   cmd;
        start_src_e src;
    } decode_t;

    function automatic order_e to_order(input logic pin);
        return pin ? ORDER_XOR : ORDER_WRAP;
    endfunction

endpackage

// File: rtl/burst_load_ctl.sv
module burst_load_ctl
    import burst_seq_pkg::*;
(
    input  logic    sel,
    input  logic    start_proc,
    input  logic    start_ctrl,
    input  logic    adv,
    output decode_t dec
);

    always_comb begin
        dec.cmd = CMD_HOLD;
        dec.src = SRC_NONE;
        if (sel && start_proc) begin
            dec.cmd = CMD_LOAD;
            dec.src = SRC_PROC;
        end else if (sel && start_ctrl) begin
            dec.cmd = CMD_LOAD;
            dec.src = SRC_CTRL;
        end else if (adv) begin
            dec.cmd = CMD_STEP;
        end
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  seq_cmd_e         cmd,
    input  logic [CNT_W-1:0] seed,
    input  logic             order_pin,
    output logic [CNT_W-1:0] seed_q,
    output logic [CNT_W-1:0] beat_q,
    output order_e           order_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seed_q  <= '0;
            beat_q  <= '0;
            order_q <= ORDER_WRAP;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    seed_q  <= seed;
                    beat_q  <= '0;
                    order_q <= to_order(order_pin);
                end
                CMD_STEP: beat_q <= beat_q + 1'b1;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  order_e           order,
    input  logic [CNT_W-1:0] seed,
    input  logic [CNT_W-1:0] beat,
    output logic [CNT_W-1:0] low
);

    logic [CNT_W-1:0] wrap_v;
    logic [CNT_W-1:0] xor_v;

    // Sum truncated to CNT_W bits wraps inside the block.
    assign wrap_v = seed + beat;

    for (genvar b = 0; b < CNT_W; b++) begin : g_xor
        assign xor_v[b] = seed[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            ORDER_XOR: low = xor_v;
            default:   low = wrap_v;
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              start_proc,
    input  logic              start_ctrl,
    input  logic              adv,
    input  logic              order_sel,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out
);

    localparam int CNT_W  = 2;
    localparam int BASE_W = ADDR_W - CNT_W;

    decode_t          dec;
    logic [CNT_W-1:0] seed_q;
    logic [CNT_W-1:0] beat_q;
    order_e           order_q;
    logic [CNT_W-1:0] low_v;
    logic [BASE_W-1:0] base_q;

    burst_load_ctl u_ctl (
        .sel        (sel),
        .start_proc (start_proc),
        .start_ctrl (start_ctrl),
        .adv        (adv),
        .dec        (dec)
    );

    burst_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .cmd       (dec.cmd),
        .seed      (addr_in[CNT_W-1:0]),
        .order_pin (order_sel),
        .seed_q    (seed_q),
        .beat_q    (beat_q),
        .order_q   (order_q)
    );

    burst_order_map #(.CNT_W(CNT_W)) u_map (
        .order (order_q),
        .seed  (seed_q),
        .beat  (beat_q),
        .low   (low_v)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (dec.cmd == CMD_LOAD) begin
            base_q <= addr_in[ADDR_W-1:CNT_W];
        end
    end

    assign addr_out = {base_q, low_v};

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W = 18
) (
    input logic              clk,
    input logic              rst,
    input logic              sel,
    input logic              start_proc,
    input logic              start_ctrl,
    input logic              adv,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out
);

    logic accept;
    assign accept = sel && (start_proc || start_ctrl);

    // R2 R3 R11 R12: accepted start shows the sampled address next cycle
    assert_start_loads_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> addr_out == $past(addr_in))
        else $error("start did not load address");

    // R5: idle edge holds
    assert_idle_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (!accept && !adv) |=> $stable(addr_out))
        else $error("address moved while idle");

    // R8 R4: upper bits move only on an accepted start
    assert_base_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(addr_out[ADDR_W-1:2]))
        else $error("upper bits moved mid-burst");

    // R6 R7: each advance changes the beat bits
    assert_step_moves_R6: assert property (@(posedge clk) disable iff (rst)
        (adv && !accept) |=> addr_out[1:0] != $past(addr_out[1:0]))
        else $error("advance left beat bits unchanged");

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .start_proc (start_proc),
    .start_ctrl (start_ctrl),
    .adv        (adv),
    .addr_in    (addr_in),
    .addr_out   (addr_out)
);

// File: tb/burst_addr_seq_tb_top.sv
`timescale 1ns/1ps
module burst_addr_seq_tb_top;

    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          sel, start_proc, start_ctrl, adv, order_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #4 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .start_proc (start_proc),
        .start_ctrl (start_ctrl),
        .adv        (adv),
        .order_sel  (order_sel),
        .addr_in    (addr_in),
        .addr_out   (addr_out)
    );

    task automatic drive(input logic s, input logic sp, input logic sc,
                         input logic a, input logic md, input logic [AW-1:0] ad);
        sel = s; start_proc = sp; start_ctrl = sc; adv = a;
        order_sel = md; addr_in = ad;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [AW-1:0] exp);
        total++;
        if (addr_out !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, addr_out, exp);
        end
    endtask

    function automatic logic [1:0] beat_low(input logic md, input logic [1:0] s,
                                            input int n);
        logic [1:0] nn;
        nn = n[1:0];
        return md ? (s ^ nn) : 2'((s + nn) % 4);
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] start_a;
        logic [AW-1:0] exp_a;
        rst = 1'b1;
        sel = 0; start_proc = 0; start_ctrl = 0; adv = 0; order_sel = 0;
        addr_in = '1;
        @(negedge clk);
        drive(1, 1, 1, 1, 1, '1);
        check("R1 reset", '0);
        rst = 1'b0;

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 3; k++) begin
                    start_a = {16'hA5C3 ^ 16'(m * 16'h111 + s * 16'h23 + k * 16'h7),
                               2'(s)};
                    // k: 0 processor, 1 controller, 2 both
                    drive(1, k != 1, k != 0, k == 2, m[0], start_a);
                    if (k == 0) check("R3 proc start", start_a);
                    else if (k == 1) check("R2 ctrl start", start_a);
                    else check("R12 both strobes / R11 start beats adv", start_a);
                    for (int n = 1; n <= 4; n++) begin
                        // mode flipped and address scrambled mid-burst
                        drive(n == 3, 1'b0, 1'b0, 1'b1, ~m[0], ~start_a);
                        exp_a = {start_a[AW-1:2], beat_low(m[0], 2'(s), n)};
                        if (n == 4) check("R9 wrap to start", start_a);
                        else if (m == 0) check("R6 linear beat / R10 / R8", exp_a);
                        else check("R7 interleaved beat / R10 / R8", exp_a);
                    end
                    drive(1, 1'b0, 1'b0, 1'b0, ~m[0], ~start_a);
                    check("R5 hold without advance", start_a);
                    drive(0, 1'b1, 1'b0, 1'b0, m[0], ~start_a);
                    check("R4 proc strobe unselected", start_a);
                    drive(0, 1'b0, 1'b1, 1'b0, m[0], ~start_a);
                    check("R4 ctrl strobe unselected", start_a);
                    drive(0, 1'b1, 1'b1, 1'b1, m[0], ~start_a);
                    exp_a = {start_a[AW-1:2], beat_low(m[0], 2'(s), 1)};
                    check("R4 strobes unselected with advance", exp_a);
                end
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule